// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for each beat of a four-beat burst into a synchronous burst memory. When a burst begins, the controller pulses the load input together with the full start address. The block then keeps the upper address bits fixed and steps only the two low bits through the chosen beat order.

Two orders are supported, and the order is chosen when the burst is loaded. In linear order the low bits count upward modulo four from the start offset. In interleaved order each beat's offset is the start offset XOR the beat count, so the order depends on where the burst starts.

An active-low advance input moves the burst to the next beat. While advance is high, the current address is held (suspend). Both outputs come from registers and change on the clock edge after the controlling inputs are sampled. All pins are plain control and address pins; no data stream passes through the block, so there is no valid/ready handshake.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset (active low) is asserted, and after it is released, addr_out and beat_out read zero until the first load.
- R2: When load is 1 at a rising edge, on the next cycle addr_out equals the sampled start_addr and beat_out is 0. Load takes precedence over advance at the same edge.
- R3: With order_sel sampled as 1 at load (interleaved), the two low bits of addr_out equal start offset XOR beat_out. Starting at offset 01, the order is 01, 00, 11, 10.
- R4: With order_sel sampled as 0 at load (linear), the two low bits of addr_out equal (start offset + beat_out) mod 4. Starting at offset 11, the order is 11, 00, 01, 10.
- R5: When load is 0 and adv_n is 0 at a rising edge, beat_out increases by one modulo 4 on the next cycle.
- R6: When load is 0 and adv_n is 1 at a rising edge, addr_out and beat_out are unchanged on the next cycle.
- R7: After the fourth beat, a further advance returns to the start offset (beat_out goes from 3 to 0). Bits above bit 1 of addr_out change only on a load.
- R8: order_sel is sampled only at a load. Changing it during a burst has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Begin a burst at start_addr |
| start_addr | input | ADDR_W | Externally supplied first address |
| order_sel | input | 1 | 1 = interleaved, 0 = linear; sampled at load |
| adv_n | input | 1 | Active-low advance to the next beat |
| addr_out | output | ADDR_W | Current word address |
| beat_out | output | 2 | Current beat index, 0 to 3 |

## Verification
The hardest situation to reach is a burst whose order input flips while the burst is running, combined with long runs of advances that wrap past the fourth beat more than once. The stimulus drives directed bursts from every start offset in both orders, with six or more advances each and suspends mixed in. A long pseudo-random phase then toggles order_sel every cycle, and issues loads that coincide with advance. A behavioural model compares both outputs on every clock.

// File: rtl/bas_pkg.sv
package bas_pkg;
  localparam int BEATS = 4;
  localparam int OFS_W = $clog2(BEATS);

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr
  import bas_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [OFS_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;
  end

  // R5
  step_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && step) |=> cnt == OFS_W'($past(cnt) + 1'b1));

  // R7
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && step && cnt == '1) |=> cnt == '0);
endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
  import bas_pkg::*;
(
  input  logic [OFS_W-1:0] first_ofs,
  input  logic [OFS_W-1:0] beat,
  input  order_e           order,
  output logic [OFS_W-1:0] ofs
);
  always_comb begin
    unique case (order)
      ORD_INTERLEAVE: ofs = first_ofs ^ beat;
      default:        ofs = first_ofs + beat;
    endcase
  end

  // R3 R4
  first_beat_chk: assert final (beat != '0 || ofs == first_ofs);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              order_sel,
  input  logic              adv_n,
  output logic [ADDR_W-1:0] addr_out,
  output logic [1:0]        beat_out
);
  localparam int HI_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] base_q;
  order_e            order_q;
  logic [OFS_W-1:0]  beat;
  logic [OFS_W-1:0]  ofs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      order_q <= ORD_LINEAR;
    end else if (load) begin
      base_q  <= start_addr;
      order_q <= order_e'(order_sel);
    end
  end

  bas_beat_ctr u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (load),
    .step  (!adv_n),
    .cnt   (beat)
  );

  bas_order_map u_map (
    .first_ofs (base_q[OFS_W-1:0]),
    .beat      (beat),
    .order     (order_q),
    .ofs       (ofs)
  );

  assign addr_out = {base_q[ADDR_W-1:OFS_W], ofs};
  assign beat_out = beat;

  // R2
  load_first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr_out == $past(start_addr) && beat_out == 2'd0));

  // R6
  suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv_n) |=> ($stable(addr_out) && $stable(beat_out)));

  // R7
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> addr_out[ADDR_W-1:OFS_W] == $past(addr_out[ADDR_W-1:OFS_W]));

  // R8
  order_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(order_q));

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |-> (addr_out == '0 && beat_out == '0));

  initial begin
    if (HI_W < 1) $error("ADDR_W must exceed the offset width");
  end
endmodule

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          order_sel = 1'b0;
  logic          adv_n = 1'b1;
  logic [AW-1:0] addr_out;
  logic [1:0]    beat_out;

  int total = 0;
  int bad = 0;

  int m_base = 0;
  int m_mode = 0;
  int m_beat = 0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .load(load), .start_addr(start_addr),
    .order_sel(order_sel), .adv_n(adv_n), .addr_out(addr_out), .beat_out(beat_out)
  );

  function automatic int exp_addr();
    int s = m_base % 4;
    int lo = m_mode ? (s ^ m_beat) : ((s + m_beat) % 4);
    return (m_base / 4) * 4 + lo;
  endfunction

  task automatic check(input string tag);
    int ea = exp_addr();
    total++;
    if (addr_out !== AW'(ea) || beat_out !== 2'(m_beat)) begin
      bad++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               tag, addr_out, beat_out, AW'(ea), m_beat);
    end
  endtask

  task automatic step(input bit ld, input int a, input bit md, input bit an,
                      input string tag);
    load = ld; start_addr = AW'(a); order_sel = md; adv_n = an;
    @(posedge clk);
    if (ld) begin
      m_base = a; m_mode = md; m_beat = 0;
    end else if (!an) begin
      m_beat = (m_beat + 1) % 4;
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    step(0, 0, 0, 1, "R1 after release");

    // Interleaved from every offset, six advances to cover the wrap
    for (int s = 0; s < 4; s++) begin
      step(1, 'h1230 + s, 1, 1, "R2 load interleaved");
      for (int k = 0; k < 6; k++) step(0, 'h5555, 0, 0, "R3 R7 interleaved advance");
    end
    // Linear from every offset
    for (int s = 0; s < 4; s++) begin
      step(1, 'hABC0 + s, 0, 1, "R2 load linear");
      for (int k = 0; k < 6; k++) step(0, 'h0, 1, 0, "R4 R7 linear advance");
    end
    // Suspend in the middle of a burst
    step(1, 'h777, 0, 1, "R2 load");
    step(0, 0, 0, 0, "R5 advance");
    for (int k = 0; k < 3; k++) step(0, 'hFFFFF, 1, 1, "R6 suspend hold");
    step(0, 0, 0, 0, "R5 advance after hold");
    // Order input flips mid-burst
    step(1, 'h402, 1, 1, "R2 load interleaved");
    for (int k = 0; k < 5; k++) step(0, 0, k % 2, 0, "R8 mode change ignored");
    // Load coincides with advance
    step(1, 'h13, 0, 0, "R2 load beats advance");
    step(1, 'hFFFFF, 1, 0, "R2 reload during burst");

    // Pseudo-random mix
    for (int i = 0; i < 3000; i++) begin
      bit ld = ($urandom % 8) == 0;
      step(ld, int'($urandom % (1 << AW)), 1'($urandom), 1'($urandom),
           "R3 R4 R5 R6 R8 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule